// File: doc/BRIEF.md
# Forwarding-Table Slot Finder

This block decides where an entry belongs in a switch forwarding table. A request carries a 48-bit station address, a 12-bit VLAN identifier and a flag that says whether the address is VLAN-qualified. A second lookup kind searches for a VLAN-only record by its identifier. After `start`, the engine reads every table word once, in ascending index order, through a read port with one cycle of latency. It classifies each word as it arrives.

One pass ranks three kinds of candidate. An entry that already holds the requested key wins first. The lowest free slot comes next. The lowest slot whose contents may be evicted comes last. The engine ends with a one-cycle `done` pulse. With it come the chosen index, a flag telling whether that index is an existing match, and a flag reporting that no slot is available. Writing the new or updated entry back into the table is left to the caller.

Table word layout, as bit ranges:

| Bits | Field |
|------|-------|
| 63:62 | age class |
| 61:60 | kind |
| 59:48 | VLAN |
| 47:0 | station address, first transmitted byte in 47:40; bit 40 is the group (multicast) bit |

Top module: `addr_alloc_engine`

## Requirements
- R1: While reset is held and just after it, `done`, `busy` and `rd_en` are low.
- R2: A `start` sampled while idle causes the following sequence.
  - Addresses 0 to DEPTH-1 are read on consecutive cycles, one per cycle, beginning in the cycle after the start edge.
  - `busy` is high from that cycle for DEPTH+1 cycles.
  - `done` is high for exactly one cycle, DEPTH+1 cycles after the start edge. In that cycle `busy` and `rd_en` are low.
- R3: In address lookup, an existing matching entry is reported with `res_hit`=1. If several entries match, the lowest matching index wins, ahead of any free or evictable slot.
- R4: The VLAN compared in address lookup is `req_vid` when `req_tagged`=1, and zero when `req_tagged`=0.
- R5: An address match counts only when all three hold:
  - the kind is 1 (address) or 3 (VLAN-qualified address);
  - the VLAN field equals the compared VLAN;
  - the address field equals `req_mac`.
  Kind 2 (VLAN-only) and kind 0 (free) entries never match an address request.
- R6: When nothing matches, the engine reports the lowest index of kind 0 (free), with `res_hit`=0.
- R7: When nothing matches and no slot is free, the engine reports the lowest evictable index, with `res_hit`=0. An entry is evictable only when all three hold:
  - its kind is 1 or 3;
  - bit 40 is 0;
  - its age class is 1 (untouched) or 3 (touched).
  Age class 0 (persistent) and age class 2 (vendor prefix) are never evicted.
- R8: When no candidate exists, `res_fail`=1, `res_hit`=0 and `res_idx`=0.
- R9: With `lookup_vlan`=1, a match is a kind-2 entry whose VLAN field equals `req_vid`. In this mode `req_tagged` and `req_mac` are ignored. The free and evictable fallbacks are unchanged.
- R10: A `start` that arrives while busy is ignored. Request inputs that change during a scan are also ignored. The sequence timing and the result follow the request captured at the accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search (accepted only when idle) |
| lookup_vlan | input | 1 | 1: VLAN-only record lookup; 0: address lookup |
| req_mac | input | 48 | Requested station address |
| req_vid | input | 12 | Requested VLAN identifier |
| req_tagged | input | 1 | Address is VLAN-qualified |
| busy | output | 1 | Search in progress |
| rd_en | output | 1 | Table read strobe |
| rd_addr | output | $clog2(DEPTH) | Table read index |
| rd_data | input | 64 | Table word, valid the cycle after the read strobe |
| done | output | 1 | One-cycle completion pulse |
| res_idx | output | $clog2(DEPTH) | Chosen index |
| res_hit | output | 1 | Chosen index holds an existing match |
| res_fail | output | 1 | No slot available |

## Verification
The stimulus places several candidates of different kinds in one table. This shows whether the engine respects the priority order, or just takes the first usable slot or the last one seen. It also includes entries that look evictable but are not: persistent, vendor-prefix, group-address and VLAN-only words. A design that tests only the age class would wrongly offer one of these as the eviction victim. Two request pairs probe the zeroing of the VLAN for untagged requests and the restriction of VLAN lookup to its own kind. A second `start` and scrambled request inputs mid-scan would restart the address stream, or change the answer, in a design that failed to latch the request.

// File: rtl/aae_pkg.sv
package aae_pkg;

    typedef enum logic [1:0] {
        ET_FREE  = 2'd0,
        ET_ADDR  = 2'd1,
        ET_VLAN  = 2'd2,
        ET_VADDR = 2'd3
    } ent_kind_e;

    typedef enum logic [1:0] {
        AC_PERSIST = 2'd0,
        AC_FRESH   = 2'd1,
        AC_PREFIX  = 2'd2,
        AC_USED    = 2'd3
    } age_cls_e;

    typedef struct packed {
        age_cls_e    age;
        ent_kind_e   kind;
        logic [11:0] vid;
        logic [47:0] mac;
    } entry_t;

    typedef enum logic {
        LK_ADDR = 1'b0,
        LK_VLAN = 1'b1
    } lk_mode_e;

    typedef struct packed {
        lk_mode_e    mode;
        logic [11:0] vid;
        logic [47:0] mac;
    } req_t;

    typedef struct packed {
        logic match;
        logic free;
        logic ageable;
    } cls_t;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_SCAN  = 2'd1,
        SQ_DRAIN = 2'd2
    } seq_state_e;

    function automatic logic is_addr_kind(ent_kind_e k);
        return (k == ET_ADDR) || (k == ET_VADDR);
    endfunction

    function automatic logic mac_is_group(logic [47:0] m);
        return m[40];
    endfunction

endpackage

// File: rtl/aae_classify.sv
module aae_classify
    import aae_pkg::*;
(
    input  req_t   req,
    input  entry_t ent,
    output cls_t   cls
);
    logic kind_addr;

    always_comb begin
        kind_addr = is_addr_kind(ent.kind);
        if (req.mode == LK_VLAN)
            cls.match = (ent.kind == ET_VLAN) && (ent.vid == req.vid);
        else
            cls.match = kind_addr && (ent.vid == req.vid) && (ent.mac == req.mac);
        cls.free    = (ent.kind == ET_FREE);
        cls.ageable = kind_addr && !mac_is_group(ent.mac) &&
                      ((ent.age == AC_FRESH) || (ent.age == AC_USED));
    end
endmodule

// File: rtl/aae_scan_seq.sv
module aae_scan_seq
    import aae_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    output logic             rd_en,
    output logic [IDX_W-1:0] rd_addr,
    output logic             busy,
    output logic             eval_v,
    output logic [IDX_W-1:0] eval_idx,
    output logic             eval_last
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    seq_state_e       state;
    logic [IDX_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            cnt      <= '0;
            eval_v   <= 1'b0;
            eval_idx <= '0;
        end else begin
            eval_v   <= rd_en;
            eval_idx <= cnt;
            case (state)
                SQ_IDLE: if (go) begin
                    state <= SQ_SCAN;
                    cnt   <= '0;
                end
                SQ_SCAN: begin
                    if (cnt == LAST) state <= SQ_DRAIN;
                    else             cnt   <= cnt + 1'b1;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign rd_en     = (state == SQ_SCAN);
    assign rd_addr   = cnt;
    assign busy      = (state != SQ_IDLE);
    assign eval_last = eval_v && (eval_idx == LAST);
endmodule

// File: rtl/aae_rank.sv
module aae_rank
    import aae_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             upd,
    input  logic [IDX_W-1:0] idx,
    input  cls_t             cls,
    input  logic             final_en,
    output logic             done,
    output logic [IDX_W-1:0] res_idx,
    output logic             res_hit,
    output logic             res_fail
);
    logic             m_v, f_v, a_v;
    logic [IDX_W-1:0] m_i, f_i, a_i;
    logic             nm_v, nf_v, na_v;
    logic [IDX_W-1:0] nm_i, nf_i, na_i;

    always_comb begin
        nm_v = m_v || (upd && cls.match);
        nm_i = m_v ? m_i : idx;
        nf_v = f_v || (upd && cls.free);
        nf_i = f_v ? f_i : idx;
        na_v = a_v || (upd && cls.ageable);
        na_i = a_v ? a_i : idx;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            m_v <= 1'b0; f_v <= 1'b0; a_v <= 1'b0;
            m_i <= '0;   f_i <= '0;   a_i <= '0;
        end else if (upd) begin
            m_v <= nm_v; f_v <= nf_v; a_v <= na_v;
            m_i <= nm_i; f_i <= nf_i; a_i <= na_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done     <= 1'b0;
            res_idx  <= '0;
            res_hit  <= 1'b0;
            res_fail <= 1'b0;
        end else begin
            done <= final_en;
            if (final_en) begin
                res_hit  <= nm_v;
                res_fail <= !(nm_v || nf_v || na_v);
                if (nm_v)      res_idx <= nm_i;
                else if (nf_v) res_idx <= nf_i;
                else if (na_v) res_idx <= na_i;
                else           res_idx <= '0;
            end
        end
    end
endmodule

// File: rtl/addr_alloc_engine.sv
module addr_alloc_engine
    import aae_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             lookup_vlan,
    input  logic [47:0]      req_mac,
    input  logic [11:0]      req_vid,
    input  logic             req_tagged,
    output logic             busy,
    output logic             rd_en,
    output logic [IDX_W-1:0] rd_addr,
    input  logic [63:0]      rd_data,
    output logic             done,
    output logic [IDX_W-1:0] res_idx,
    output logic             res_hit,
    output logic             res_fail
);
    logic             go;
    req_t             req_q;
    cls_t             cls;
    logic             eval_v, eval_last;
    logic [IDX_W-1:0] eval_idx;

    assign go = start && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else if (go) begin
            req_q.mode <= lookup_vlan ? LK_VLAN : LK_ADDR;
            req_q.vid  <= (lookup_vlan || req_tagged) ? req_vid : 12'd0;
            req_q.mac  <= req_mac;
        end
    end

    aae_scan_seq #(.DEPTH(DEPTH)) u_seq (
        .clk(clk), .rst(rst), .go(go),
        .rd_en(rd_en), .rd_addr(rd_addr), .busy(busy),
        .eval_v(eval_v), .eval_idx(eval_idx), .eval_last(eval_last)
    );

    aae_classify u_cls (
        .req(req_q), .ent(entry_t'(rd_data)), .cls(cls)
    );

    aae_rank #(.IDX_W(IDX_W)) u_rank (
        .clk(clk), .rst(rst), .clear(go),
        .upd(eval_v), .idx(eval_idx), .cls(cls), .final_en(eval_last),
        .done(done), .res_idx(res_idx), .res_hit(res_hit), .res_fail(res_fail)
    );
endmodule

// File: rtl/aae_chk.sv
module aae_chk #(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             rd_en,
    input logic [IDX_W-1:0] rd_addr,
    input logic             done,
    input logic [IDX_W-1:0] res_idx,
    input logic             res_hit,
    input logic             res_fail
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    // R2
    scan_start_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (rd_en && busy && rd_addr == '0));

    // R2
    scan_step_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr != LAST) |=> (rd_en && rd_addr == IDX_W'($past(rd_addr) + 1'b1)));

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !rd_en));

    // R8
    fail_shape_chk: assert property (@(posedge clk) disable iff (rst)
        (done && res_fail) |-> (!res_hit && res_idx == '0));

    // R10
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && start) |=> !(rd_en && rd_addr == '0));
endmodule

bind addr_alloc_engine aae_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy),
    .rd_en(rd_en), .rd_addr(rd_addr), .done(done),
    .res_idx(res_idx), .res_hit(res_hit), .res_fail(res_fail)
);

// File: tb/addr_alloc_engine_tb.sv
module addr_alloc_engine_tb;
    localparam int DEPTH = 16;
    localparam int IDX_W = $clog2(DEPTH);
    localparam logic [47:0] MAC_A  = 48'h0200_1122_3344;
    localparam logic [47:0] MAC_B  = 48'h0200_5566_7788;
    localparam logic [47:0] MAC_MC = 48'h0100_5e00_0001;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic             lookup_vlan = 1'b0;
    logic [47:0]      req_mac = '0;
    logic [11:0]      req_vid = '0;
    logic             req_tagged = 1'b0;
    logic             busy, rd_en, done, res_hit, res_fail;
    logic [IDX_W-1:0] rd_addr, res_idx;
    logic [63:0]      rd_data = '0;
    logic [63:0]      mem [DEPTH];

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #5 clk = ~clk;

    always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

    addr_alloc_engine #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .start(start), .lookup_vlan(lookup_vlan),
        .req_mac(req_mac), .req_vid(req_vid), .req_tagged(req_tagged),
        .busy(busy), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .done(done), .res_idx(res_idx), .res_hit(res_hit), .res_fail(res_fail)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung (actual %0d cycles, expected fewer)", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input int age, input int kind, input int vid, input logic [47:0] mac);
        return {age[1:0], kind[1:0], vid[11:0], mac};
    endfunction

    task automatic fill(input logic [63:0] w);
        for (int i = 0; i < DEPTH; i++) mem[i] = w;
    endtask

    // Behavioural reference: three independent searches, then priority.
    task automatic expect_res(input logic vmode, input logic [47:0] mac, input logic [11:0] vid,
                              input logic vq, output int e_idx, output logic e_hit, output logic e_fail);
        int hit_i = -1, free_i = -1, age_i = -1;
        for (int i = 0; i < DEPTH; i++) begin
            int kind = int'(mem[i][61:60]);
            int age  = int'(mem[i][63:62]);
            int ev   = int'(mem[i][59:48]);
            bit m;
            if (vmode) m = (kind == 2) && (ev == int'(vid));
            else m = (kind == 1 || kind == 3) && (ev == (vq ? int'(vid) : 0)) && (mem[i][47:0] == mac);
            if (m && hit_i < 0) hit_i = i;
            if (kind == 0 && free_i < 0) free_i = i;
            if ((kind == 1 || kind == 3) && !mem[i][40] && (age == 1 || age == 3) && age_i < 0) age_i = i;
        end
        e_hit = (hit_i >= 0);
        e_fail = 1'b0;
        if (hit_i >= 0)       e_idx = hit_i;
        else if (free_i >= 0) e_idx = free_i;
        else if (age_i >= 0)  e_idx = age_i;
        else begin e_idx = 0; e_fail = 1'b1; end
    endtask

    task automatic run(input logic vmode, input logic [47:0] mac, input logic [11:0] vid,
                       input logic vq, input logic poke, input string tag);
        int e_idx; logic e_hit, e_fail;
        expect_res(vmode, mac, vid, vq, e_idx, e_hit, e_fail);
        @(negedge clk);
        start = 1'b1; lookup_vlan = vmode; req_mac = mac; req_vid = vid; req_tagged = vq;
        @(negedge clk);
        start = 1'b0;
        for (int n = 0; n <= DEPTH + 1; n++) begin
            if (poke && n == 3) begin
                start = 1'b1; req_mac = ~mac; req_vid = ~vid; lookup_vlan = ~vmode; req_tagged = ~vq;
            end else if (poke && n == 4) begin
                start = 1'b0;
            end
            chk(rd_en == (n < DEPTH), poke ? "R10 rd_en" : "R2 rd_en", rd_en, n < DEPTH);
            if (n < DEPTH) chk(rd_addr == IDX_W'(n), poke ? "R10 rd_addr" : "R2 rd_addr", rd_addr, n);
            chk(busy == (n <= DEPTH), "R2 busy", busy, n <= DEPTH);
            chk(done == (n == DEPTH + 1), "R2 done", done, n == DEPTH + 1);
            if (n == DEPTH + 1) begin
                chk(res_idx == IDX_W'(e_idx), {tag, " idx"}, res_idx, e_idx);
                chk(res_hit == e_hit, {tag, " hit"}, res_hit, e_hit);
                chk(res_fail == e_fail, {tag, " fail"}, res_fail, e_fail);
            end else begin
                @(negedge clk);
            end
        end
    endtask

    initial begin
        fill('0);
        @(negedge clk);
        chk(!done && !busy && !rd_en, "R1 reset outputs", {done, busy, rd_en}, 0);
        @(negedge clk);
        rst = 1'b0;
        chk(!done && !busy && !rd_en, "R1 after reset", {done, busy, rd_en}, 0);

        // R6: lowest free slot among VLAN-only records
        fill(mk(0, 2, 7, '0)); mem[11] = '0; mem[13] = '0;
        run(1'b0, MAC_A, 12'd0, 1'b0, 1'b0, "R6 free");

        // R3: match beats an earlier free slot; lowest match wins
        fill(mk(0, 1, 0, MAC_B)); mem[4] = '0;
        mem[10] = mk(0, 1, 0, MAC_A); mem[12] = mk(3, 1, 0, MAC_A);
        run(1'b0, MAC_A, 12'd0, 1'b0, 1'b0, "R3 match");

        // R10: second start and scrambled inputs mid-scan are ignored
        run(1'b0, MAC_A, 12'd0, 1'b0, 1'b1, "R10 ignore");

        // R4: tagged compares req_vid, untagged compares zero
        fill(mk(0, 1, 0, MAC_B));
        mem[3] = mk(0, 3, 5, MAC_A); mem[6] = mk(0, 3, 0, MAC_A);
        run(1'b0, MAC_A, 12'd5, 1'b1, 1'b0, "R4 tagged");
        run(1'b0, MAC_A, 12'd5, 1'b0, 1'b0, "R4 untagged");

        // R5: kind 2 with identical fields must not match
        fill(mk(0, 2, 99, MAC_B)); mem[2] = mk(0, 2, 0, MAC_A);
        mem[12] = mk(3, 1, 0, MAC_B);
        run(1'b0, MAC_A, 12'd0, 1'b0, 1'b0, "R5 kind filter");

        // R7: persistent, prefix, group and VLAN-only words skipped
        fill(mk(0, 1, 0, MAC_B));
        mem[1] = mk(2, 1, 0, MAC_B); mem[3] = mk(1, 1, 0, MAC_MC);
        mem[5] = mk(1, 2, 0, MAC_B); mem[14] = mk(1, 3, 4, MAC_B);
        mem[15] = mk(3, 1, 0, MAC_B);
        run(1'b0, MAC_A, 12'd0, 1'b0, 1'b0, "R7 evict");

        // R8: nothing usable
        fill(mk(0, 1, 0, MAC_B));
        run(1'b0, MAC_A, 12'd0, 1'b0, 1'b0, "R8 no space");

        // R9: VLAN lookup matches kind 2 only; req_tagged ignored
        fill(mk(0, 1, 0, MAC_B));
        mem[1] = mk(0, 3, 7, MAC_B); mem[8] = mk(0, 2, 7, '0); mem[9] = mk(0, 2, 7, '0);
        run(1'b1, MAC_A, 12'd7, 1'b0, 1'b0, "R9 vlan hit");
        run(1'b1, MAC_A, 12'd9, 1'b1, 1'b0, "R9 vlan miss");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule